// File: doc/BRIEF.md
# Emulated EEPROM Operation Controller

This block is the control-register front end of a flash-backed emulated EEPROM. Software sees a six-bit register that holds three enable/trigger pairs, one pair each for erase, write and read. A trigger counts only if its enable was already set before the access that raises it. When a trigger is accepted, the block launches exactly one operation toward the memory sequencer. It raises a CPU stall for the whole operation and, on completion, clears the bits that hardware owns.

An internal down-counter stands in for the latency of the array. The number of cycles for each operation type is a parameter. The sequencer side shows a one-cycle start pulse, the operation code, a busy level and a one-cycle done pulse. Register accesses that arrive while an operation runs are dropped. Reads of the register always return its current contents.

Top module: `eemu_op_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all six register bits, the busy state, the start pulse and the stall output.
- R2: The register bit layout is: bit 5 erase enable, bit 4 erase trigger, bit 3 write enable, bit 2 write trigger, bit 1 read enable, bit 0 read trigger. Enable bits written while idle read back exactly as written.
- R3: A trigger bit written as 1 while its enable bit is 0 starts nothing, and the trigger reads back 0.
- R4: A write that changes any enable bit from 0 to 1 and also sets any trigger bit starts no operation. Its enable bits are stored and all trigger bits read back 0.
- R5: An accepted trigger produces the following in the cycle after the write: mem_start high for one cycle, cpu_stall and mem_busy high, the trigger bit reading 1, and mem_op carrying 1 for read, 2 for write or 3 for erase.
- R6: An operation keeps cpu_stall high for exactly RD_CYC, WR_CYC or ER_CYC cycles for read, write or erase. mem_done pulses in the last of these cycles, and cpu_stall is low in the cycle after.
- R7: On completion the active trigger bit returns to 0. Erase clears the erase enable and write clears the write enable, but the read enable stays set after a read.
- R8: Register writes that arrive while an operation is in progress change no register bit and start no later operation.
- R9: When several triggers are validly armed in one write, erase wins over write and write wins over read. The losing triggers read back 0 and are never run.
- R10: A write that clears an enable bit while it sets the matching trigger starts nothing and leaves that enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Current register contents |
| mem_start | output | 1 | One-cycle operation launch pulse |
| mem_op | output | 2 | Active operation code: 0 none, 1 read, 2 write, 3 erase |
| mem_busy | output | 1 | Operation in progress |
| mem_done | output | 1 | One-cycle pulse in the last busy cycle |
| cpu_stall | output | 1 | Halts the CPU while an operation runs |

## Verification
The bench sets an enable and its trigger in a single access, both for the same pair and across pairs. A design that let this through would launch from one register write, so the bench watches for a start pulse after that write. It counts stall cycles for each operation type, which catches off-by-one counters that stretch or shorten the stall or misplace the done pulse. It writes all ones in the middle of an operation, which catches a design that lets a busy-time write alter the bits or queue a second operation. It also checks that the read enable survives completion while the erase and write enables do not, and that the operation picked from a multi-trigger write follows the erase, write, read priority.

// File: rtl/eemu_pkg.sv
package eemu_pkg;

  localparam int CTRL_W = 6;
  localparam int NPAIR  = 3;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ERASE = 2'd3
  } op_e;

  // pair index: 2 = erase, 1 = write, 0 = read; enable at 2i+1, trigger at 2i
  function automatic logic [NPAIR-1:0] enables_of(input logic [CTRL_W-1:0] r);
    logic [NPAIR-1:0] e;
    for (int i = 0; i < NPAIR; i++) e[i] = r[2*i+1];
    return e;
  endfunction

  function automatic logic [NPAIR-1:0] triggers_of(input logic [CTRL_W-1:0] r);
    logic [NPAIR-1:0] t;
    for (int i = 0; i < NPAIR; i++) t[i] = r[2*i];
    return t;
  endfunction

  function automatic logic [CTRL_W-1:0] pack_pairs(input logic [NPAIR-1:0] en,
                                                   input logic [NPAIR-1:0] go);
    logic [CTRL_W-1:0] r;
    for (int i = 0; i < NPAIR; i++) begin
      r[2*i+1] = en[i];
      r[2*i]   = go[i];
    end
    return r;
  endfunction

  function automatic op_e pick_op(input logic [NPAIR-1:0] armed);
    if (armed[2])      return OP_ERASE;
    else if (armed[1]) return OP_WRITE;
    else if (armed[0]) return OP_READ;
    else               return OP_NONE;
  endfunction

  function automatic logic [NPAIR-1:0] pair_mask(input op_e op);
    case (op)
      OP_ERASE: return 3'b100;
      OP_WRITE: return 3'b010;
      OP_READ:  return 3'b001;
      default:  return 3'b000;
    endcase
  endfunction

  // enables that hardware drops when the given operation finishes
  function automatic logic [NPAIR-1:0] auto_clear_en(input op_e op);
    case (op)
      OP_ERASE: return 3'b100;
      OP_WRITE: return 3'b010;
      default:  return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/eemu_arm_decode.sv
module eemu_arm_decode
  import eemu_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              wr_req,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              busy,
  output logic              wr_accept,
  output logic              launch,
  output op_e               launch_op
);

  logic [NPAIR-1:0] old_en;
  logic [NPAIR-1:0] new_en;
  logic [NPAIR-1:0] new_go;
  logic [NPAIR-1:0] rising_en;
  logic [NPAIR-1:0] armed;
  logic             blocked;

  always_comb begin
    old_en    = enables_of(ctrl_q);
    new_en    = enables_of(wdata);
    new_go    = triggers_of(wdata);
    rising_en = new_en & ~old_en;
    // a trigger needs its enable set before the access and kept by it
    armed     = new_go & old_en & new_en;
    blocked   = (|rising_en) && (|new_go);
    wr_accept = wr_req && !busy;
    launch    = wr_accept && !blocked && (|armed);
    launch_op = launch ? pick_op(armed) : OP_NONE;
  end

endmodule

// File: rtl/eemu_ctrl_reg.sv
module eemu_ctrl_reg
  import eemu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_accept,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              launch,
  input  op_e               launch_op,
  input  logic              op_done,
  input  op_e               active_op,
  output logic [CTRL_W-1:0] ctrl_q
);

  logic [NPAIR-1:0] en_q;
  logic [NPAIR-1:0] go_q;
  logic [NPAIR-1:0] wr_en_bits;
  logic [NPAIR-1:0] set_go;
  logic [NPAIR-1:0] drop_en;

  always_comb begin
    wr_en_bits = enables_of(wdata);
    set_go     = launch ? pair_mask(launch_op) : '0;
    drop_en    = auto_clear_en(active_op);
  end

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[i] <= 1'b0;
        go_q[i] <= 1'b0;
      end else if (op_done) begin
        go_q[i] <= 1'b0;
        if (drop_en[i]) en_q[i] <= 1'b0;
      end else if (wr_accept) begin
        en_q[i] <= wr_en_bits[i];
        go_q[i] <= set_go[i];
      end
    end
  end

  assign ctrl_q = pack_pairs(en_q, go_q);

endmodule

// File: rtl/eemu_op_timer.sv
module eemu_op_timer
  import eemu_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 4,
  parameter int ER_CYC = 6
)(
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  op_e  launch_op,
  output logic busy,
  output logic start,
  output logic done,
  output op_e  active_op
);

  localparam int MAX_CYC = (ER_CYC > WR_CYC) ? ((ER_CYC > RD_CYC) ? ER_CYC : RD_CYC)
                                             : ((WR_CYC > RD_CYC) ? WR_CYC : RD_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  function automatic logic [CNT_W-1:0] span_of(input op_e op);
    case (op)
      OP_ERASE: return CNT_W'(ER_CYC - 1);
      OP_WRITE: return CNT_W'(WR_CYC - 1);
      OP_READ:  return CNT_W'(RD_CYC - 1);
      default:  return '0;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             start_q;
  op_e              op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
      op_q    <= OP_NONE;
    end else if (launch) begin
      busy_q  <= 1'b1;
      start_q <= 1'b1;
      cnt_q   <= span_of(launch_op);
      op_q    <= launch_op;
    end else begin
      start_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          op_q   <= OP_NONE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign start     = start_q;
  assign done      = busy_q && (cnt_q == '0);
  assign active_op = op_q;

endmodule

// File: rtl/eemu_op_ctrl.sv
module eemu_op_ctrl
  import eemu_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 4,
  parameter int ER_CYC = 6
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [5:0] reg_wdata,
  output logic [5:0] reg_rdata,
  output logic       mem_start,
  output logic [1:0] mem_op,
  output logic       mem_busy,
  output logic       mem_done,
  output logic       cpu_stall
);

  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_accept;
  logic              arm_launch;
  op_e               arm_op;
  logic              op_busy;
  logic              op_start;
  logic              op_done;
  op_e               op_active;

  eemu_arm_decode u_arm (
    .ctrl_q    (ctrl_q),
    .wr_req    (reg_wr),
    .wdata     (reg_wdata),
    .busy      (op_busy),
    .wr_accept (wr_accept),
    .launch    (arm_launch),
    .launch_op (arm_op)
  );

  eemu_ctrl_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .wr_accept (wr_accept),
    .wdata     (reg_wdata),
    .launch    (arm_launch),
    .launch_op (arm_op),
    .op_done   (op_done),
    .active_op (op_active),
    .ctrl_q    (ctrl_q)
  );

  eemu_op_timer #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .ER_CYC (ER_CYC)
  ) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .launch    (arm_launch),
    .launch_op (arm_op),
    .busy      (op_busy),
    .start     (op_start),
    .done      (op_done),
    .active_op (op_active)
  );

  assign reg_rdata = ctrl_q;
  assign mem_start = op_start;
  assign mem_op    = op_active;
  assign mem_busy  = op_busy;
  assign mem_done  = op_done;
  assign cpu_stall = op_busy;

endmodule

// File: rtl/eemu_op_ctrl_chk.sv
module eemu_op_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [5:0] reg_rdata,
  input logic       mem_start,
  input logic [1:0] mem_op,
  input logic       mem_busy,
  input logic       mem_done,
  input logic       cpu_stall,
  input logic       arm_launch,
  input logic [1:0] arm_op
);

  // R1: reset leaves everything idle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (reg_rdata == 6'd0 && !cpu_stall && !mem_start));

  // R5: an accepted launch shows start, stall and the chosen code next cycle
  p_launch_start_r5: assert property (@(posedge clk) disable iff (rst)
    arm_launch |=> (mem_start && cpu_stall && mem_op == $past(arm_op)));

  // R5: start is a single-cycle pulse
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    mem_start |=> !mem_start);

  // R6: stall drops right after the done pulse
  p_done_release_r6: assert property (@(posedge clk) disable iff (rst)
    mem_done |=> !cpu_stall);

  // R7: read keeps its enable, write drops its enable
  p_read_keeps_en_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_done && mem_op == 2'd1) |=> (reg_rdata[1] && !reg_rdata[0]));
  p_write_drops_en_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_done && mem_op == 2'd2) |=> (reg_rdata[3:2] == 2'b00));

  // R8: during an operation the register only moves at completion
  p_busy_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_busy && !mem_done) |=> $stable(reg_rdata));
  p_no_launch_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_busy && reg_wr) |-> !arm_launch);

  // R9: at most one trigger bit is ever held
  p_one_trigger_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_rdata[4], reg_rdata[2], reg_rdata[0]}));

endmodule

bind eemu_op_ctrl eemu_op_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_rdata  (reg_rdata),
  .mem_start  (mem_start),
  .mem_op     (mem_op),
  .mem_busy   (mem_busy),
  .mem_done   (mem_done),
  .cpu_stall  (cpu_stall),
  .arm_launch (arm_launch),
  .arm_op     (arm_op)
);

// File: tb/test_eemu_op_ctrl.sv
module test_eemu_op_ctrl;

  localparam int RD_N = 2;
  localparam int WR_N = 4;
  localparam int ER_N = 6;

  logic       clk = 1'b0;
  logic       rst;
  logic       reg_wr;
  logic [5:0] reg_wdata;
  logic [5:0] reg_rdata;
  logic       mem_start;
  logic [1:0] mem_op;
  logic       mem_busy;
  logic       mem_done;
  logic       cpu_stall;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  eemu_op_ctrl #(.RD_CYC(RD_N), .WR_CYC(WR_N), .ER_CYC(ER_N)) i_eemu_op_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_start(mem_start), .mem_op(mem_op),
    .mem_busy(mem_busy), .mem_done(mem_done), .cpu_stall(cpu_stall)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one register access; returns at the negedge after the capturing edge
  task automatic wr(input logic [5:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = 6'd0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    reg_wr = 1'b0;
    reg_wdata = 6'd0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // arm then trigger one operation and follow it to the end
  task automatic run_op(input logic [5:0] en, input logic [5:0] go, input int code,
                        input int len, input logic [5:0] after, input string tag);
    int n;
    int done_at;
    wr(en);
    wr(en | go);
    check({tag, " R5 start"}, int'(mem_start), 1);
    check({tag, " R5 op code"}, int'(mem_op), code);
    check({tag, " R5 trigger reads 1"}, int'(reg_rdata), int'(en | go));
    n = 0;
    done_at = 0;
    while (cpu_stall && n < 50) begin
      n++;
      if (mem_done) done_at = n;
      @(negedge clk);
    end
    check({tag, " R6 stall length"}, n, len);
    check({tag, " R6 done in last cycle"}, done_at, len);
    check({tag, " R7 bits after completion"}, int'(reg_rdata), int'(after));
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rdata", int'(reg_rdata), 0);
    check("R1 stall", int'(cpu_stall), 0);
    check("R1 busy", int'(mem_busy), 0);
  endtask

  task automatic t_layout();
    wr(6'b101010);
    check("R2 enables read back", int'(reg_rdata), 6'h2A);
    check("R2 no start", int'(mem_start), 0);
    wr(6'b000000);
    check("R2 enables cleared", int'(reg_rdata), 0);
  endtask

  task automatic t_unarmed();
    wr(6'b000001);
    check("R3 read trig no enable start", int'(mem_start), 0);
    check("R3 read trig reads 0", int'(reg_rdata), 0);
    wr(6'b010100);
    check("R3 erase/write trig no enable", int'(mem_start) + int'(cpu_stall), 0);
    check("R3 bits stay 0", int'(reg_rdata), 0);
  endtask

  task automatic t_same_write();
    wr(6'b001100);
    check("R4 enable+trigger together start", int'(mem_start), 0);
    check("R4 enable kept trigger dropped", int'(reg_rdata), 6'h08);
    wr(6'b001110);
    check("R4 cross-pair rise blocks", int'(mem_start), 0);
    check("R4 cross-pair bits", int'(reg_rdata), 6'h0A);
    wr(6'b000000);
  endtask

  task automatic t_ops();
    run_op(6'h20, 6'h10, 3, ER_N, 6'h00, "erase");
    run_op(6'h08, 6'h04, 2, WR_N, 6'h00, "write");
    run_op(6'h02, 6'h01, 1, RD_N, 6'h02, "read");
    wr(6'b000000);
  endtask

  task automatic t_busy_ignore();
    wr(6'h08);
    wr(6'h0C);
    check("R8 launched", int'(cpu_stall), 1);
    wr(6'h3F);
    check("R8 bits unchanged while busy", int'(reg_rdata), 6'h0C);
    check("R8 still stalled", int'(cpu_stall), 1);
    while (cpu_stall) @(negedge clk);
    check("R8 cleared after write op", int'(reg_rdata), 0);
    for (int k = 0; k < 4; k++) begin
      check("R8 no later start", int'(mem_start) + int'(cpu_stall), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_priority();
    wr(6'h2A);
    wr(6'h3F);
    check("R9 erase wins", int'(mem_op), 3);
    check("R9 only erase trigger", int'(reg_rdata), 6'h3A);
    while (cpu_stall) @(negedge clk);
    check("R9 after erase", int'(reg_rdata), 6'h0A);
    wr(6'h0F);
    check("R9 write over read", int'(mem_op), 2);
    while (cpu_stall) @(negedge clk);
    check("R9 read trigger dropped", int'(reg_rdata), 6'h02);
    check("R9 no follow-on start", int'(mem_start), 0);
    wr(6'h00);
  endtask

  task automatic t_clear_inhibit();
    wr(6'h02);
    wr(6'h01);
    check("R10 clearing enable blocks read", int'(mem_start), 0);
    check("R10 enable left 0", int'(reg_rdata), 0);
    wr(6'h08);
    wr(6'h04);
    check("R10 clearing enable blocks write", int'(mem_start) + int'(cpu_stall), 0);
  endtask

  initial begin
    rst = 1'b1;
    reg_wr = 1'b0;
    reg_wdata = 6'd0;
    t_reset();
    t_layout();
    t_unarmed();
    t_same_write();
    t_ops();
    t_busy_ignore();
    t_priority();
    t_clear_inhibit();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule